// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block is the central arbiter for a shared bus on which grants ripple through a chain of devices. It watches a set of prioritised interrupt request lines and one direct-memory-access request line. For each request line it drives one grant line, and it never drives more than one grant at a time. It also samples the bus handshake lines: selection acknowledge, bus busy, interrupt and master sync. From these it decides when a grant must be withdrawn and when the bus is quiet enough for a new grant to go out.

A grant stays out until the chosen device raises acknowledge, or until a timeout expires because no device answered. After acknowledge the arbiter waits. If the device takes the bus as master, the arbiter follows it to the bus-owned phase. If the device simply drops acknowledge without taking the bus, the arbiter treats this as a passive release. A device on a priority level can use this to hand its slot early to a pending memory-access request. When a priority-granted device asserts busy and interrupt, the arbiter reports whether a vector was present. A missing vector is flagged as a zero-vector error.

All inputs are sampled on the rising clock edge, and every output is registered. The block moves no data, so it has no valid/ready interface. Every pin is a plain level or a one-cycle pulse. Reset is synchronous and active high.

Top module: `daisy_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, all grant outputs and all three pulse outputs are low after that edge, and the arbiter is idle.
- R2: A grant is issued only at an edge where `sack_in`, `bbsy_in`, `intr_in` and `msyn_in` are all sampled low and some request is high. The grant output is high after that same edge.
- R3: The memory-access request beats every priority level. Among the priority requests, a higher bit index of `br_req` wins. Grant bit i of `bg_out` answers request bit i of `br_req`.
- R4: At most one of `npg_out` and the bits of `bg_out` is high in any cycle.
- R5: If `sack_in` is sampled high while a grant is out, the grant is low after that edge.
- R6: After an acknowledge, no new grant is issued before an edge at which `sack_in` is sampled low.
- R7: After an acknowledge, if `sack_in` is sampled low while `bbsy_in` is low, `passive_rel` pulses high for one cycle, and neither `intr_ok` nor `zero_vec_err` pulses. A pending memory-access request can then be granted at the next quiet edge.
- R8: After an acknowledge of a priority grant, if `bbsy_in`, `intr_in` and `vec_valid_in` are all sampled high, `intr_ok` pulses high for one cycle.
- R9: After an acknowledge of a priority grant, if `bbsy_in` and `intr_in` are sampled high while `vec_valid_in` is low, `zero_vec_err` pulses high for one cycle.
- R10: A grant that sees no acknowledge is held for exactly `TMO_CYCLES` cycles and is then removed. The arbiter then returns to idle.
- R11: While the bus is owned, meaning `bbsy_in` has been sampled high after an acknowledge, no grant is issued. Once `bbsy_in` is sampled low, the arbiter returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_req | input | NUM_LVL | Priority interrupt requests; a higher index means a higher priority |
| npr_req | input | 1 | Direct-memory-access request |
| sack_in | input | 1 | Selection acknowledge from the bus |
| bbsy_in | input | 1 | Bus busy |
| intr_in | input | 1 | Interrupt line |
| msyn_in | input | 1 | Master sync |
| vec_valid_in | input | 1 | High when a vector is present on the data lines |
| bg_out | output | NUM_LVL | Priority grants, one per level |
| npg_out | output | 1 | Direct-memory-access grant |
| intr_ok | output | 1 | One-cycle pulse: an interrupt with a vector was recognised |
| zero_vec_err | output | 1 | One-cycle pulse: an interrupt arrived without a vector |
| passive_rel | output | 1 | One-cycle pulse: acknowledge was dropped without the bus being taken |

## Verification
The assertions assume that every handshake input is a clean synchronous level that holds across each sampling edge. They also assume `vec_valid_in` is meaningful only while `intr_in` is high. The stimulus changes inputs only on the falling edge, and it raises busy and interrupt only after an acknowledge, so every bus cycle follows the order the requirements describe. The reference model in the bench evaluates the same sampled inputs at each rising edge, and its outputs are compared with the design's on every falling edge.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_WAIT  = 2'd2,
    ST_OWNED = 2'd3
  } arb_state_e;
endpackage

// File: rtl/arb_pick.sv
// Fixed-priority picker: memory-access request first, then the highest level.
module arb_pick #(
  parameter int NUM_LVL = 4
) (
  input  logic [NUM_LVL-1:0] br_req,
  input  logic               npr_req,
  output logic [NUM_LVL:0]   pick_o
);
  logic [NUM_LVL-1:0] blocked;

  for (genvar gi = 0; gi < NUM_LVL; gi++) begin : g_lvl
    if (gi == NUM_LVL - 1) begin : g_top
      assign blocked[gi] = npr_req;
    end else begin : g_low
      assign blocked[gi] = npr_req | (|br_req[NUM_LVL-1:gi+1]);
    end
    assign pick_o[gi] = br_req[gi] & ~blocked[gi];
  end
  assign pick_o[NUM_LVL] = npr_req;

  always_comb begin
    assert_pick_onehot_R3: assert ($onehot0(pick_o));
  end
endmodule

// File: rtl/arb_watchdog.sv
// Counts the cycles a grant has gone unanswered.
module arb_watchdog #(
  parameter int TMO_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  assert_wd_bound_R10: assert property (@(posedge clk) disable iff (rst)
    (clear_i |=> cnt_q == '0));
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter #(
  parameter int NUM_LVL    = 4,
  parameter int TMO_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] br_req,
  input  logic               npr_req,
  input  logic               sack_in,
  input  logic               bbsy_in,
  input  logic               intr_in,
  input  logic               msyn_in,
  input  logic               vec_valid_in,
  output logic [NUM_LVL-1:0] bg_out,
  output logic               npg_out,
  output logic               intr_ok,
  output logic               zero_vec_err,
  output logic               passive_rel
);
  import arb_pkg::*;
  localparam int GW = NUM_LVL + 1;

  arb_state_e    state_q, state_d;
  logic [GW-1:0] grant_q, grant_d, pick;
  logic          dma_q, dma_d;
  logic          ok_q, ok_d, err_q, err_d, pas_q, pas_d;
  logic          expired, bus_quiet, any_req;

  arb_pick #(.NUM_LVL(NUM_LVL)) u_pick (
    .br_req (br_req),
    .npr_req(npr_req),
    .pick_o (pick)
  );

  arb_watchdog #(.TMO_CYCLES(TMO_CYCLES)) u_wd (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (state_q != ST_GRANT),
    .run_i    (state_q == ST_GRANT && !sack_in),
    .expired_o(expired)
  );

  assign bus_quiet = !sack_in && !bbsy_in && !intr_in && !msyn_in;
  assign any_req   = npr_req || (|br_req);

  always_comb begin
    state_d = state_q;
    grant_d = grant_q;
    dma_d   = dma_q;
    ok_d    = 1'b0;
    err_d   = 1'b0;
    pas_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (any_req && bus_quiet) begin
          grant_d = pick;
          dma_d   = npr_req;
          state_d = ST_GRANT;
        end
      end
      ST_GRANT: begin
        if (sack_in) begin
          grant_d = '0;
          state_d = ST_WAIT;
        end else if (expired) begin
          grant_d = '0;
          state_d = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (bbsy_in) begin
          state_d = ST_OWNED;
          if (!dma_q && intr_in) begin
            ok_d  = vec_valid_in;
            err_d = !vec_valid_in;
          end
        end else if (!sack_in) begin
          pas_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_OWNED: begin
        if (!bbsy_in) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      grant_q <= '0;
      dma_q   <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      pas_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      grant_q <= grant_d;
      dma_q   <= dma_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
      pas_q   <= pas_d;
    end
  end

  assign bg_out       = grant_q[NUM_LVL-1:0];
  assign npg_out      = grant_q[NUM_LVL];
  assign intr_ok      = ok_q;
  assign zero_vec_err = err_q;
  assign passive_rel  = pas_q;

  assert_one_grant_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({npg_out, bg_out}));
  assert_sack_drops_grant_R5: assert property (@(posedge clk) disable iff (rst)
    ((|{npg_out, bg_out}) && sack_in) |=> !(|{npg_out, bg_out}));
  assert_grant_needs_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(npg_out) |-> $past(!sack_in && !bbsy_in && !intr_in && !msyn_in));
  assert_no_grant_under_sack_R6: assert property (@(posedge clk) disable iff (rst)
    (!(|{npg_out, bg_out}) && sack_in) |=> !(|{npg_out, bg_out}));
  assert_passive_clean_R7: assert property (@(posedge clk) disable iff (rst)
    passive_rel |-> ($past(!sack_in && !bbsy_in) && !intr_ok && !zero_vec_err));
  assert_vector_seen_R8: assert property (@(posedge clk) disable iff (rst)
    intr_ok |-> $past(bbsy_in && intr_in && vec_valid_in));
  assert_zero_vector_R9: assert property (@(posedge clk) disable iff (rst)
    zero_vec_err |-> $past(bbsy_in && intr_in && !vec_valid_in));
  assert_owned_no_grant_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OWNED && bbsy_in) |=> !(|{npg_out, bg_out}));
endmodule

// File: tb/tb_daisy_arbiter.sv
module tb_daisy_arbiter;
  localparam int NL  = 4;
  localparam int TMO = 16;
  localparam int GW  = NL + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0] br_req = '0;
  logic npr_req = 0, sack_in = 0, bbsy_in = 0, intr_in = 0, msyn_in = 0, vec_valid_in = 0;
  logic [NL-1:0] bg_out;
  logic npg_out, intr_ok, zero_vec_err, passive_rel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  daisy_arbiter #(.NUM_LVL(NL), .TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst(rst), .br_req(br_req), .npr_req(npr_req), .sack_in(sack_in),
    .bbsy_in(bbsy_in), .intr_in(intr_in), .msyn_in(msyn_in), .vec_valid_in(vec_valid_in),
    .bg_out(bg_out), .npg_out(npg_out), .intr_ok(intr_ok),
    .zero_vec_err(zero_vec_err), .passive_rel(passive_rel)
  );

  // Behavioural reference: phase 0 idle, 1 granted, 2 acknowledged, 3 owned
  int m_phase = 0;
  int m_wait = 0;
  bit m_dma = 0;
  logic [GW-1:0] m_grant = '0;
  bit m_ok = 0, m_err = 0, m_pas = 0;

  always @(posedge clk) begin
    m_ok = 0; m_err = 0; m_pas = 0;
    if (rst) begin
      m_phase = 0; m_grant = '0; m_dma = 0; m_wait = 0;
    end else begin
      case (m_phase)
        0: if ((npr_req || br_req != 0) && !sack_in && !bbsy_in && !intr_in && !msyn_in) begin
             m_grant = '0;
             if (npr_req) m_grant[NL] = 1'b1;
             else begin
               for (int i = NL - 1; i >= 0; i--)
                 if (br_req[i] && m_grant == 0) m_grant[i] = 1'b1;
             end
             m_dma = npr_req; m_wait = 1; m_phase = 1;
           end
        1: if (sack_in) begin m_grant = '0; m_phase = 2; end
           else if (m_wait == TMO) begin m_grant = '0; m_phase = 0; end
           else m_wait++;
        2: if (bbsy_in) begin
             m_phase = 3;
             if (!m_dma && intr_in) begin m_ok = vec_valid_in; m_err = !vec_valid_in; end
           end else if (!sack_in) begin m_pas = 1; m_phase = 0; end
        default: if (!bbsy_in) m_phase = 0;
      endcase
    end
  end

  task automatic check(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison with the model
  always @(negedge clk) begin
    if (!done) begin
      check({npg_out, bg_out} === m_grant, "R4/R3 grant vector vs model", 32'({npg_out, bg_out}), 32'(m_grant));
      check({intr_ok, zero_vec_err, passive_rel} === {m_ok, m_err, m_pas},
            "R7/R8/R9 pulses vs model", 32'({intr_ok, zero_vec_err, passive_rel}), 32'({m_ok, m_err, m_pas}));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet_all();
    br_req = '0; npr_req = 0; sack_in = 0; bbsy_in = 0; intr_in = 0; msyn_in = 0; vec_valid_in = 0;
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          failures++;
          $display("FAIL watchdog actual=hung expected=finished");
          done = 1;
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none

    step(3);
    check({npg_out, bg_out, intr_ok, zero_vec_err, passive_rel} == 0, "R1 reset outputs",
          32'({npg_out, bg_out}), 0);
    rst = 0;
    step(1);

    // Priority grant, acknowledge, interrupt with vector
    br_req = 4'b0010; step(1);
    check(bg_out == 4'b0010 && !npg_out, "R2 grant after quiet edge", 32'(bg_out), 32'h2);
    sack_in = 1; br_req = '0; step(1);
    check({npg_out, bg_out} == 0, "R5 sack removes grant", 32'({npg_out, bg_out}), 0);
    bbsy_in = 1; intr_in = 1; vec_valid_in = 1; step(1);
    check(intr_ok == 1, "R8 vector interrupt", 32'(intr_ok), 1);
    br_req = 4'b1000; step(1);
    check(intr_ok == 0 && bg_out == 0, "R11 owned, no grant", 32'(bg_out), 0);
    sack_in = 0; intr_in = 0; vec_valid_in = 0; step(2);
    check(bg_out == 0, "R11 still owned while busy", 32'(bg_out), 0);
    bbsy_in = 0; br_req = '0; step(2);

    // Memory access beats all levels; then a passive release
    br_req = 4'b1001; npr_req = 1; step(1);
    check(npg_out == 1 && bg_out == 0, "R3 memory access wins", 32'({npg_out, bg_out}), 32'h10);
    sack_in = 1; npr_req = 0; br_req = '0; step(1);
    check(npg_out == 0, "R5 memory grant removed", 32'(npg_out), 0);
    sack_in = 0; step(1);
    check(passive_rel == 1 && intr_ok == 0 && zero_vec_err == 0, "R7 passive release", 32'(passive_rel), 1);
    step(1);

    // Highest level wins
    br_req = 4'b1001; step(1);
    check(bg_out == 4'b1000, "R3 highest level", 32'(bg_out), 32'h8);
    sack_in = 1; br_req = '0; step(1);
    bbsy_in = 1; intr_in = 1; vec_valid_in = 0; step(1);
    check(zero_vec_err == 1 && intr_ok == 0, "R9 zero vector flagged", 32'(zero_vec_err), 1);
    quiet_all(); step(2);

    // Memory request held off by master sync
    npr_req = 1; msyn_in = 1; step(2);
    check(npg_out == 0, "R2 no grant while master sync high", 32'(npg_out), 0);
    msyn_in = 0; step(1);
    check(npg_out == 1, "R2 grant once quiet", 32'(npg_out), 1);
    npr_req = 0; sack_in = 1; step(1);

    // Acknowledge held: no new grant
    br_req = 4'b0100; step(3);
    check(bg_out == 0, "R6 no grant while sack held", 32'(bg_out), 0);
    br_req = '0; sack_in = 0; step(2);

    // Early release in favour of a memory request
    br_req = 4'b0001; step(1);
    check(bg_out == 4'b0001, "R2 low level granted", 32'(bg_out), 1);
    br_req = '0; npr_req = 1; sack_in = 1; step(1);
    sack_in = 0; step(1);
    check(passive_rel == 1, "R7 early release", 32'(passive_rel), 1);
    step(1);
    check(npg_out == 1, "R7 memory request granted after release", 32'(npg_out), 1);
    npr_req = 0; sack_in = 1; step(1);
    sack_in = 0; step(2);

    // Timeout on an unanswered grant
    br_req = 4'b0100; step(1);
    br_req = '0;
    check(bg_out == 4'b0100, "R10 grant out", 32'(bg_out), 32'h4);
    step(TMO - 1);
    check(bg_out == 4'b0100, "R10 held for full window", 32'(bg_out), 32'h4);
    step(1);
    check(bg_out == 0, "R10 grant removed on timeout", 32'(bg_out), 0);
    step(3);

    // Reset mid-grant
    br_req = 4'b0010; step(1);
    rst = 1; step(1);
    check({npg_out, bg_out} == 0, "R1 reset clears grant", 32'({npg_out, bg_out}), 0);
    rst = 0; br_req = '0; step(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule